// File: doc/BRIEF.md
# Reset Strap Latch and Boot Decoder

This block reads device configuration straps from pads that double as the external memory interface's address and bank outputs, plus one separate PCI-enable strap. While the synchronous reset is held, the pad levels pass through a synchronizer and are captured continuously. The sample present at the last reset edge is kept, and it stays frozen from reset release until the next reset. After release the block turns the shared pads around, so the memory interface drives them. It raises a reset-status flag in the same cycle, which tells external strap drivers to let go.

The latched 4-bit boot-mode field is decoded into a boot-source code and a peripheral enable vector. Every peripheral is off after reset unless the boot source needs it. A software enable register is ORed on top, so software can turn on more peripherals but cannot turn off the boot peripheral. The block also decodes a clock-source select bit for the memory interface. It flags reserved boot codes, and it flags a PCI boot whose general-purpose config field is not zero.

Top module: `strap_boot_ctrl`

## Requirements
- R1: The strap inputs pass through a two-flop synchronizer. The captured value is the pad level present at the third-last clock edge of reset. A pad change made after that edge is not captured.
- R2: While `rst` is low, `straps_o` (address straps in bits [21:2], bank straps in bits [1:0]) and `pci_en_o` do not change, whatever the pads do.
- R3: `rst_stat_o` and `pad_oe_o` are 0 in every cycle that follows a clock edge at which `rst` was high. Both become 1 at the first clock edge at which `rst` is low.
- R4: `mem_addr_pad_o` and `mem_bank_pad_o` carry `mem_addr_i` and `mem_bank_i` one clock later.
- R5: The boot mode is taken from address strap bits [19:16] and decoded onto `boot_src_o`:
  - 0000 gives 0 (none).
  - 0001 gives 1 (host port).
  - 0100 gives 2 (8-bit external ROM).
  - 0101 gives 3 (I2C master).
  - 0110 gives 4 (I2C slave).
  - 0111 gives 5 (PCI host).
  - 1000 to 1111 give 6 (serial RapidIO).
- R6: After release, the boot source sets exactly one bit of `periph_en_o`. Host port sets bit 0, external ROM sets bit 1, either I2C mode sets bit 2, PCI sets bit 3 and RapidIO sets bit 4. Boot source none sets no bit.
- R7: Boot modes 0010 and 0011 give `boot_src_o` = 0, `rsvd_o` = 1 and no auto-enabled peripheral.
- R8: Boot mode 0111 with address strap bits [14:12] not equal to 000 gives `cfg_err_o` = 1, `boot_src_o` = 0 and no auto-enabled peripheral.
- R9: `clk_sel_o` equals address strap bit 15. 0 selects the external clock input and 1 selects the internal divided clock.
- R10: `pci_en_o` equals the PCI-enable strap sampled under the same rule as R1.
- R11: `periph_en_o` is all zero during reset. After release it holds only the boot-derived bit until software writes.
- R12: A write (`sw_wr_i` high) is ignored while `rst_stat_o` is 0. Otherwise it loads `sw_wdata_i` into a register that is ORed onto `periph_en_o` from the next cycle. Writing 0 cannot clear the boot-derived bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while high |
| cfg_addr_pad_i | input | ADDR_W (20) | Address pad levels read as straps |
| cfg_bank_pad_i | input | BANK_W (2) | Bank pad levels read as straps |
| pci_en_pad_i | input | 1 | PCI-enable strap pad |
| mem_addr_i | input | ADDR_W | Address from the memory interface to drive onto the pads |
| mem_bank_i | input | BANK_W | Bank select from the memory interface |
| mem_addr_pad_o | output | ADDR_W | Registered address pad output |
| mem_bank_pad_o | output | BANK_W | Registered bank pad output |
| pad_oe_o | output | 1 | Pad output enable, 0 while sampling |
| rst_stat_o | output | 1 | Reset status; 0 while straps may be driven externally |
| sw_wr_i | input | 1 | Software enable register write strobe |
| sw_wdata_i | input | PERIPH_N (8) | Software enable write data |
| straps_o | output | ADDR_W+BANK_W | Latched address and bank straps |
| pci_en_o | output | 1 | Latched PCI-enable strap |
| boot_src_o | output | 3 | Decoded boot source code |
| clk_sel_o | output | 1 | Memory interface clock source select |
| cfg_err_o | output | 1 | PCI boot with non-zero config field |
| rsvd_o | output | 1 | Reserved boot code latched |
| periph_en_o | output | PERIPH_N | Peripheral enables (boot OR software) |

## Verification
The hardest case to reach is a strap change that lands inside the synchronizer window just before release. The pad has already moved, but the captured value must still be the older level. The bench holds one pattern through reset, switches the pads on the falling edge after the third-last reset edge, and then releases two edges later. It expects the first pattern, and a second run with one more reset edge shows the new pattern. A software write in the very cycle of release, while reset status is still low, is the other narrow case. The bench drops reset and raises the write strobe on the same falling edge.

// File: rtl/strap_pkg.sv
`timescale 1ns/1ps
package strap_pkg;
  localparam int BOOTM_HI   = 19;
  localparam int BOOTM_LO   = 16;
  localparam int CLKSEL_BIT = 15;
  localparam int GPCFG_HI   = 14;
  localparam int GPCFG_LO   = 12;

  localparam int PEN_HOST = 0;
  localparam int PEN_EROM = 1;
  localparam int PEN_I2C  = 2;
  localparam int PEN_PCI  = 3;
  localparam int PEN_SRIO = 4;
  localparam int PEN_MIN  = 5;

  typedef enum logic [2:0] {
    BOOT_NONE = 3'd0,
    BOOT_HOST = 3'd1,
    BOOT_EROM = 3'd2,
    BOOT_I2CM = 3'd3,
    BOOT_I2CS = 3'd4,
    BOOT_PCI  = 3'd5,
    BOOT_SRIO = 3'd6
  } boot_src_e;

  typedef struct packed {
    boot_src_e src;
    logic      clk_sel;
    logic      cfg_err;
    logic      rsvd;
  } boot_dec_t;
endpackage

// File: rtl/strap_sync.sv
`timescale 1ns/1ps
module strap_sync #(
  parameter int W      = 23,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) stg[g] <= stg[g-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
`timescale 1ns/1ps
module strap_capture #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= d;
  end
endmodule

// File: rtl/pad_turnaround.sv
`timescale 1ns/1ps
module pad_turnaround #(
  parameter int ADDR_W = 20,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              oe_o,
  output logic              stat_o
);
  always_ff @(posedge clk) begin
    addr_o <= addr_i;
    bank_o <= bank_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_o   <= 1'b0;
      stat_o <= 1'b0;
    end else begin
      oe_o   <= 1'b1;
      stat_o <= 1'b1;
    end
  end
endmodule

// File: rtl/boot_decoder.sv
`timescale 1ns/1ps
module boot_decoder
  import strap_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int PERIPH_N = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr_straps,
  output boot_dec_t           dec_o,
  output logic [PERIPH_N-1:0] auto_en_o
);
  logic [3:0]          mode;
  logic [2:0]          gpcfg;
  boot_dec_t           dec_d;
  logic [PERIPH_N-1:0] en_d;

  assign mode  = addr_straps[BOOTM_HI:BOOTM_LO];
  assign gpcfg = addr_straps[GPCFG_HI:GPCFG_LO];

  always_comb begin
    dec_d         = '0;
    dec_d.src     = BOOT_NONE;
    dec_d.clk_sel = addr_straps[CLKSEL_BIT];
    case (mode)
      4'b0000: dec_d.src = BOOT_NONE;
      4'b0001: dec_d.src = BOOT_HOST;
      4'b0010,
      4'b0011: dec_d.rsvd = 1'b1;
      4'b0100: dec_d.src = BOOT_EROM;
      4'b0101: dec_d.src = BOOT_I2CM;
      4'b0110: dec_d.src = BOOT_I2CS;
      4'b0111: begin
        if (gpcfg == 3'b000) dec_d.src = BOOT_PCI;
        else                 dec_d.cfg_err = 1'b1;
      end
      default: dec_d.src = BOOT_SRIO;
    endcase
  end

  always_comb begin
    en_d = '0;
    case (dec_d.src)
      BOOT_HOST:            en_d[PEN_HOST] = 1'b1;
      BOOT_EROM:            en_d[PEN_EROM] = 1'b1;
      BOOT_I2CM, BOOT_I2CS: en_d[PEN_I2C]  = 1'b1;
      BOOT_PCI:             en_d[PEN_PCI]  = 1'b1;
      BOOT_SRIO:            en_d[PEN_SRIO] = 1'b1;
      default:              en_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_o     <= '0;
      auto_en_o <= '0;
    end else begin
      dec_o     <= dec_d;
      auto_en_o <= en_d;
    end
  end
endmodule

// File: rtl/periph_enable.sv
`timescale 1ns/1ps
module periph_enable #(
  parameter int PERIPH_N = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                open_i,
  input  logic                wr_i,
  input  logic [PERIPH_N-1:0] wdata_i,
  input  logic [PERIPH_N-1:0] auto_en_i,
  output logic [PERIPH_N-1:0] en_o
);
  logic [PERIPH_N-1:0] sw_q;

  always_ff @(posedge clk) begin
    if (rst)                 sw_q <= '0;
    else if (wr_i && open_i) sw_q <= wdata_i;
  end

  assign en_o = sw_q | auto_en_i;
endmodule

// File: rtl/strap_boot_ctrl.sv
`timescale 1ns/1ps
module strap_boot_ctrl
  import strap_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int BANK_W      = 2,
  parameter int PERIPH_N    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        cfg_addr_pad_i,
  input  logic [BANK_W-1:0]        cfg_bank_pad_i,
  input  logic                     pci_en_pad_i,
  input  logic [ADDR_W-1:0]        mem_addr_i,
  input  logic [BANK_W-1:0]        mem_bank_i,
  output logic [ADDR_W-1:0]        mem_addr_pad_o,
  output logic [BANK_W-1:0]        mem_bank_pad_o,
  output logic                     pad_oe_o,
  output logic                     rst_stat_o,
  input  logic                     sw_wr_i,
  input  logic [PERIPH_N-1:0]      sw_wdata_i,
  output logic [ADDR_W+BANK_W-1:0] straps_o,
  output logic                     pci_en_o,
  output logic [2:0]               boot_src_o,
  output logic                     clk_sel_o,
  output logic                     cfg_err_o,
  output logic                     rsvd_o,
  output logic [PERIPH_N-1:0]      periph_en_o
);
  localparam int STRAP_W = ADDR_W + BANK_W + 1;

  logic [STRAP_W-1:0]  pad_raw;
  logic [STRAP_W-1:0]  pad_sync;
  logic [STRAP_W-1:0]  latched;
  boot_dec_t           dec;
  logic [PERIPH_N-1:0] auto_en;

  assign pad_raw = {cfg_addr_pad_i, cfg_bank_pad_i, pci_en_pad_i};

  strap_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (pad_raw),
    .q   (pad_sync)
  );

  strap_capture #(.W(STRAP_W)) u_cap (
    .clk (clk),
    .rst (rst),
    .d   (pad_sync),
    .q   (latched)
  );

  pad_turnaround #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_pad (
    .clk    (clk),
    .rst    (rst),
    .addr_i (mem_addr_i),
    .bank_i (mem_bank_i),
    .addr_o (mem_addr_pad_o),
    .bank_o (mem_bank_pad_o),
    .oe_o   (pad_oe_o),
    .stat_o (rst_stat_o)
  );

  boot_decoder #(.ADDR_W(ADDR_W), .PERIPH_N(PERIPH_N)) u_dec (
    .clk         (clk),
    .rst         (rst),
    .addr_straps (latched[STRAP_W-1 -: ADDR_W]),
    .dec_o       (dec),
    .auto_en_o   (auto_en)
  );

  periph_enable #(.PERIPH_N(PERIPH_N)) u_pen (
    .clk       (clk),
    .rst       (rst),
    .open_i    (rst_stat_o),
    .wr_i      (sw_wr_i),
    .wdata_i   (sw_wdata_i),
    .auto_en_i (auto_en),
    .en_o      (periph_en_o)
  );

  assign straps_o   = latched[STRAP_W-1:1];
  assign pci_en_o   = latched[0];
  assign boot_src_o = dec.src;
  assign clk_sel_o  = dec.clk_sel;
  assign cfg_err_o  = dec.cfg_err;
  assign rsvd_o     = dec.rsvd;
endmodule

// File: rtl/strap_boot_ctrl_chk.sv
`timescale 1ns/1ps
module strap_boot_ctrl_chk
  import strap_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int BANK_W   = 2,
  parameter int PERIPH_N = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     pad_oe_o,
  input logic                     rst_stat_o,
  input logic                     sw_wr_i,
  input logic [PERIPH_N-1:0]      sw_wdata_i,
  input logic [ADDR_W+BANK_W-1:0] straps_o,
  input logic                     pci_en_o,
  input logic [2:0]               boot_src_o,
  input logic                     cfg_err_o,
  input logic                     rsvd_o,
  input logic [PERIPH_N-1:0]      periph_en_o
);
  // R2
  straps_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    rst_stat_o |=> ($stable(straps_o) && $stable(pci_en_o)));

  // R3
  oe_off_in_reset_chk: assert property (@(posedge clk)
    rst |=> (!pad_oe_o && !rst_stat_o));

  // R3
  oe_on_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (pad_oe_o && rst_stat_o));

  // R11
  en_off_before_status_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_stat_o |-> (periph_en_o == '0));

  // R6
  pci_boot_enables_chk: assert property (@(posedge clk) disable iff (rst)
    (boot_src_o == BOOT_PCI) |-> periph_en_o[PEN_PCI]);

  // R7
  rsvd_no_boot_chk: assert property (@(posedge clk) disable iff (rst)
    rsvd_o |-> (boot_src_o == BOOT_NONE));

  // R8
  cfg_err_no_boot_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> (boot_src_o == BOOT_NONE && !periph_en_o[PEN_PCI]));

  // R12
  sw_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_stat_o && sw_wr_i) |=> ((periph_en_o & $past(sw_wdata_i)) == $past(sw_wdata_i)));
endmodule

bind strap_boot_ctrl strap_boot_ctrl_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .PERIPH_N(PERIPH_N)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pad_oe_o    (pad_oe_o),
  .rst_stat_o  (rst_stat_o),
  .sw_wr_i     (sw_wr_i),
  .sw_wdata_i  (sw_wdata_i),
  .straps_o    (straps_o),
  .pci_en_o    (pci_en_o),
  .boot_src_o  (boot_src_o),
  .cfg_err_o   (cfg_err_o),
  .rsvd_o      (rsvd_o),
  .periph_en_o (periph_en_o)
);

// File: tb/strap_boot_ctrl_test.sv
`timescale 1ns/1ps
module strap_boot_ctrl_test;
  localparam int NV = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] cfg_addr = '0;
  logic [1:0]  cfg_bank = '0;
  logic        pci_pad = 1'b0;
  logic [19:0] mem_addr = '0;
  logic [1:0]  mem_bank = '0;
  logic [19:0] addr_pad;
  logic [1:0]  bank_pad;
  logic        oe, stat;
  logic        sw_wr = 1'b0;
  logic [7:0]  sw_wdata = '0;
  logic [21:0] straps;
  logic        pci_en, clk_sel, cfg_err, rsvd;
  logic [2:0]  src;
  logic [7:0]  pen;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  strap_boot_ctrl uut (
    .clk(clk), .rst(rst),
    .cfg_addr_pad_i(cfg_addr), .cfg_bank_pad_i(cfg_bank), .pci_en_pad_i(pci_pad),
    .mem_addr_i(mem_addr), .mem_bank_i(mem_bank),
    .mem_addr_pad_o(addr_pad), .mem_bank_pad_o(bank_pad),
    .pad_oe_o(oe), .rst_stat_o(stat),
    .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata),
    .straps_o(straps), .pci_en_o(pci_en), .boot_src_o(src),
    .clk_sel_o(clk_sel), .cfg_err_o(cfg_err), .rsvd_o(rsvd), .periph_en_o(pen)
  );

  // vector layout: addr[36:17] bank[16:15] pci[14] src[13:11] en[10:3] clk[2] err[1] rsvd[0]
  localparam logic [36:0] VECS [NV] = '{
    {20'h00000, 2'd0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0},
    {20'h10000, 2'd1, 1'b1, 3'd1, 8'h01, 1'b0, 1'b0, 1'b0},
    {20'h28000, 2'd0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b1},
    {20'h30000, 2'd3, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1},
    {20'h40ABC, 2'd2, 1'b0, 3'd2, 8'h02, 1'b0, 1'b0, 1'b0},
    {20'h58000, 2'd0, 1'b1, 3'd3, 8'h04, 1'b1, 1'b0, 1'b0},
    {20'h60000, 2'd1, 1'b0, 3'd4, 8'h04, 1'b0, 1'b0, 1'b0},
    {20'h70123, 2'd0, 1'b1, 3'd5, 8'h08, 1'b0, 1'b0, 1'b0},
    {20'h71000, 2'd0, 1'b1, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0},
    {20'hFFFFF, 2'd3, 1'b1, 3'd6, 8'h10, 1'b1, 1'b0, 1'b0},
    {20'h80000, 2'd2, 1'b0, 3'd6, 8'h10, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_reset(input logic [19:0] a, input logic [1:0] b, input logic p);
    @(negedge clk);
    rst = 1'b1; cfg_addr = a; cfg_bank = b; pci_pad = p;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // reset state R3 R11
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 oe in reset", {63'd0, oe}, 64'd0);
    check("R3 status in reset", {63'd0, stat}, 64'd0);
    check("R11 enables in reset", {56'd0, pen}, 64'd0);

    // vector table R5 R6 R7 R8 R9 R10 R1
    for (int i = 0; i < NV; i++) begin
      run_reset(VECS[i][36:17], VECS[i][16:15], VECS[i][14]);
      check("R1 straps", {42'd0, straps}, {42'd0, VECS[i][36:15]});
      check("R10 pci strap", {63'd0, pci_en}, {63'd0, VECS[i][14]});
      check("R5 boot src", {61'd0, src}, {61'd0, VECS[i][13:11]});
      check("R6 auto enable", {56'd0, pen}, {56'd0, VECS[i][10:3]});
      check("R9 clock select", {63'd0, clk_sel}, {63'd0, VECS[i][2]});
      check("R8 cfg error", {63'd0, cfg_err}, {63'd0, VECS[i][1]});
      check("R7 reserved", {63'd0, rsvd}, {63'd0, VECS[i][0]});
      check("R3 status after release", {62'd0, oe, stat}, 64'd3);
    end

    // R2 straps frozen against pad changes
    run_reset(20'h58000, 2'd1, 1'b1);
    @(negedge clk);
    cfg_addr = 20'h0F0F0; cfg_bank = 2'd2; pci_pad = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 straps frozen", {42'd0, straps}, {42'd0, 20'h58000, 2'd1});
    check("R2 pci frozen", {63'd0, pci_en}, 64'd1);
    check("R2 boot src held", {61'd0, src}, 64'd3);

    // R4 pad outputs follow memory interface one cycle later
    mem_addr = 20'hA5A5A; mem_bank = 2'd2;
    @(posedge clk);
    @(negedge clk);
    check("R4 addr pad", {44'd0, addr_pad}, {44'd0, 20'hA5A5A});
    check("R4 bank pad", {62'd0, bank_pad}, 64'd2);

    // R1 late change inside synchronizer window is not captured
    @(negedge clk);
    rst = 1'b1; cfg_addr = 20'h40000; cfg_bank = 2'd1; pci_pad = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    cfg_addr = 20'h10000; cfg_bank = 2'd2; pci_pad = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 late change ignored", {42'd0, straps}, {42'd0, 20'h40000, 2'd1});
    check("R1 late change src", {61'd0, src}, 64'd2);
    // one more reset edge lets it through
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 new value after longer reset", {42'd0, straps}, {42'd0, 20'h10000, 2'd2});

    // R12 write during the release cycle is ignored
    @(negedge clk);
    rst = 1'b1; cfg_addr = 20'h00000; cfg_bank = 2'd0; pci_pad = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; sw_wr = 1'b1; sw_wdata = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    sw_wr = 1'b0;
    check("R12 early write ignored", {56'd0, pen}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R11 only boot bits", {56'd0, pen}, 64'd0);

    // R12 write ORs onto boot bit and cannot clear it
    run_reset(20'h70000, 2'd0, 1'b1);
    check("R6 pci boot bit", {56'd0, pen}, 64'h08);
    sw_wr = 1'b1; sw_wdata = 8'h00;
    @(posedge clk);
    @(negedge clk);
    sw_wr = 1'b0;
    check("R12 zero write keeps boot bit", {56'd0, pen}, 64'h08);
    sw_wr = 1'b1; sw_wdata = 8'h21;
    @(posedge clk);
    @(negedge clk);
    sw_wr = 1'b0;
    check("R12 write ored", {56'd0, pen}, 64'h29);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule